// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

This block is one general-purpose I/O port that sits on an 8-bit internal data bus. Each implemented pin has an output data latch and a direction latch. A separate single-cycle strobe loads each one from the bus. A third strobe loads one port-wide, active-low weak pull-up control from bus bit 0.

Pad control comes out as two enables per pin: one for the high-side driver and one for the low-side driver. When a pin is in input mode, both enables are off. One designated pin has no high-side driver, so it behaves as open-drain.

A read strobe captures the synchronized pin levels into a holding register that drives the read bus. A second read strobe places the direction latch on the read bus instead. The read bus keeps its value until the next read strobe.

Top module: `gpio_port`

## Requirements
- R1: A direction bit of 0 makes that pin an output and a 1 makes it an input, chosen per pin. An output pin with data 1 asserts its high enable; an output pin with data 0 asserts its low enable.
- R2: A data write (`wr_data`) loads the output latch of every implemented pin, input-mode pins included. A later switch of such a pin to output drives the written value.
- R3: An input-mode pin has both drive enables at 0, and a pin never has both enables at 1.
- R4: Pin `OD_PIN` (default 4) never asserts its high enable. In output mode a 0 asserts its low enable and a 1 releases the line.
- R5: `pull_en` is 1 only on pins that are inputs while the pull-up control is 0. The control is written from bus bit 0 with `wr_pull` and applies to the whole port.
- R6: After reset, all pins are inputs, the output latch is 0, the pull-up control is 1, and `bus_rdata` is 0.
- R7: `rd_data` loads the synchronized pin levels into `bus_rdata` one clock later. `bus_rdata` then holds while no read strobe is present, whatever the pins do.
- R8: Pin inputs pass through two flops before capture, so a pin change needs two clock edges before a read strobe can see it.
- R9: `rd_dir` puts the direction latch on `bus_rdata` one clock later. If `rd_data` and `rd_dir` are high in the same cycle, the pin data is returned.
- R10: Bits `PINS` to 7 of `bus_rdata` always read 0, and those bus bits are ignored on every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wdata | input | BUS_W | Write data bus |
| wr_data | input | 1 | Load output data latch |
| wr_dir | input | 1 | Load direction latch (1 = input) |
| wr_pull | input | 1 | Load pull-up control from bit 0 (0 = pull-ups on) |
| rd_data | input | 1 | Capture pin levels onto read bus |
| rd_dir | input | 1 | Place direction latch on read bus |
| bus_rdata | output | BUS_W | Read data bus |
| pin_in | input | PINS | Pad input levels |
| drv_hi | output | PINS | High-side drive enable per pin |
| drv_lo | output | PINS | Low-side drive enable per pin |
| pull_en | output | PINS | Weak pull-up enable per pin |

## Verification
The bench writes data while some pins are inputs and then turns those pins into outputs. A design that gated the latch write by direction would then drive stale values. The bench checks that the open-drain pin never drives high, even with a 1 latched, which catches a port built from identical pin slices. It reads a pin immediately after it changes, then again two cycles later, which exposes a synchronizer with the wrong depth. It toggles the pins after a read to confirm the read bus holds, and it raises both read strobes together to pin down which source wins.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int BUS_W  = 8,
  parameter int PINS   = 5,
  parameter int OD_PIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic             wr_pull,
  input  logic             rd_data,
  input  logic             rd_dir,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  drv_hi,
  output logic [PINS-1:0]  drv_lo,
  output logic [PINS-1:0]  pull_en
);
  localparam logic [PINS-1:0] ALL_IN = '1;

  logic [PINS-1:0] dout_q, dir_q, sync1_q, sync2_q;
  logic            pull_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= ALL_IN;
      pull_n_q <= 1'b1;
      sync1_q  <= '0;
      sync2_q  <= '0;
      bus_rdata <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (wr_data) dout_q   <= bus_wdata[PINS-1:0];
      if (wr_dir)  dir_q    <= bus_wdata[PINS-1:0];
      if (wr_pull) pull_n_q <= bus_wdata[0];
      if (rd_data)     bus_rdata <= BUS_W'(sync2_q);
      else if (rd_dir) bus_rdata <= BUS_W'(dir_q);
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i == OD_PIN) begin : g_od
      assign drv_hi[i] = 1'b0;
    end else begin : g_pp
      assign drv_hi[i] = ~dir_q[i] & dout_q[i];
    end
    assign drv_lo[i]  = ~dir_q[i] & ~dout_q[i];
    assign pull_en[i] = dir_q[i] & ~pull_n_q;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int BUS_W  = 8,
  parameter int PINS   = 5,
  parameter int OD_PIN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             wr_dir,
  input logic             rd_data,
  input logic             rd_dir,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [PINS-1:0]  dir_q,
  input logic [PINS-1:0]  drv_hi,
  input logic [PINS-1:0]  drv_lo,
  input logic [PINS-1:0]  pull_en
);
  p_no_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi & drv_lo) == '0);
  p_input_floats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_hi | drv_lo) & dir_q) == '0);
  p_pull_inputs_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & ~dir_q) == '0);
  p_dir_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(bus_wdata[PINS-1:0]));
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data && !rd_dir) |=> $stable(bus_rdata));
  p_rd_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dir && !rd_data) |=> bus_rdata == BUS_W'($past(dir_q)));
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> PINS) == '0);
endmodule

bind gpio_port gpio_port_chk #(.BUS_W(BUS_W), .PINS(PINS), .OD_PIN(OD_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_dir(wr_dir),
  .rd_data(rd_data), .rd_dir(rd_dir), .bus_rdata(bus_rdata), .dir_q(dir_q),
  .drv_hi(drv_hi), .drv_lo(drv_lo), .pull_en(pull_en)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] bus_wdata = '0;
  logic       wr_data = 0, wr_dir = 0, wr_pull = 0, rd_data = 0, rd_dir = 0;
  logic [7:0] bus_rdata;
  logic [4:0] pin_in = '0, drv_hi, drv_lo, pull_en;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  gpio_port uut (.clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_data(wr_data),
    .wr_dir(wr_dir), .wr_pull(wr_pull), .rd_data(rd_data), .rd_dir(rd_dir),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .drv_hi(drv_hi), .drv_lo(drv_lo),
    .pull_en(pull_en));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int kind, logic [7:0] v);
    bus_wdata = v;
    wr_data = (kind == 0); wr_dir = (kind == 1); wr_pull = (kind == 2);
    @(negedge clk);
    wr_data = 0; wr_dir = 0; wr_pull = 0;
  endtask

  task automatic rd(logic dat, logic dir, logic [7:0] exp, string tag);
    rd_data = dat; rd_dir = dir;
    @(negedge clk);
    rd_data = 0; rd_dir = 0;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic drv(string tag, logic [4:0] hi, logic [4:0] lo, logic [4:0] pu);
    chk({tag, " drv_hi"}, 8'(drv_hi), 8'(hi));
    chk({tag, " drv_lo"}, 8'(drv_lo), 8'(lo));
    chk({tag, " pull_en"}, 8'(pull_en), 8'(pu));
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    drv("R6 reset", 5'h00, 5'h00, 5'h00);
    chk("R6 reset rdata", bus_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rd(0, 1, 8'h1F, "R6 reset dir all inputs");

    wr(1, 8'h00);
    wr(0, 8'h15);
    drv("R1 R4 out 15", 5'h05, 5'h0A, 5'h00);
    wr(0, 8'h0A);
    drv("R1 R4 out 0A", 5'h0A, 5'h15, 5'h00);

    wr(1, 8'h03);
    drv("R3 pins0-1 input", 5'h08, 5'h14, 5'h00);
    wr(0, 8'h00);
    drv("R2 write with inputs", 5'h00, 5'h1C, 5'h00);
    wr(1, 8'h00);
    drv("R2 latch reached inputs", 5'h00, 5'h1F, 5'h00);

    wr(1, 8'h03);
    wr(2, 8'hFE);
    drv("R5 pull on inputs", 5'h00, 5'h1C, 5'h03);
    wr(1, 8'h00);
    drv("R5 outputs no pull", 5'h00, 5'h1F, 5'h00);
    wr(1, 8'h1F);
    drv("R5 all inputs pulled", 5'h00, 5'h00, 5'h1F);
    wr(2, 8'h01);
    drv("R5 pull off", 5'h00, 5'h00, 5'h00);

    wr(1, 8'hE0);
    rd(0, 1, 8'h00, "R10 dir upper ignored");
    wr(0, 8'hE0);
    drv("R10 data upper ignored", 5'h00, 5'h1F, 5'h00);

    pin_in = 5'h13;
    repeat (3) @(negedge clk);
    rd(1, 0, 8'h13, "R7 read pins 13");
    pin_in = 5'h0C;
    repeat (4) @(negedge clk);
    chk("R7 rdata holds", bus_rdata, 8'h13);

    pin_in = 5'h1F;
    rd(1, 0, 8'h0C, "R8 read too early sees old");
    @(negedge clk);
    rd(1, 0, 8'h1F, "R8 read after sync");

    wr(1, 8'h05);
    pin_in = 5'h02;
    repeat (3) @(negedge clk);
    rd(1, 1, 8'h02, "R9 both strobes data wins");
    rd(0, 1, 8'h05, "R9 dir readback");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule